// File: doc/BRIEF.md
# Two-Port Semaphore Token Bank

This block keeps a small bank of hardware semaphores that two agents, called the left and the right port, use to claim shared resources. It holds no data memory. A port claims a semaphore by writing 0 to it and gives it back by writing 1. It learns whether it holds the semaphore by reading it back: 0 means the port owns it, and 1 means the semaphore is free or held by the other side.

Each semaphore remembers a claim from each side on its own. A claim made while the other side owns the token stays pending. The token passes to the waiting side in the same clock edge that the owner gives it up. Reads go through a per-port output register, so a write from the other port cannot disturb a value that has already been captured. Everything runs on one clock with an active-low asynchronous reset.

Top module: `sem_token_bank`

## Requirements
- R1: The bank holds NUM_SEM (default 8) semaphores. Address bits [2:0] pick the semaphore, and every higher address bit is ignored.
- R2: A write uses only data bit 0. Bit 0 = 0 places a claim and bit 0 = 1 withdraws it. All other data bits are ignored.
- R3: When a free semaphore is claimed, the claiming port reads 0 and the other port reads 1.
- R4: A claim written by the non-owner leaves what both ports read unchanged. If the non-owner writes 1 before the owner gives the token up, its pending claim is cancelled.
- R5: If the owner writes 1 while the other side has a pending claim, the other side owns the semaphore from that edge on.
- R6: If the owner writes 1 and no claim is pending, the semaphore becomes free and both ports read 1.
- R7: A read puts the semaphore value on every data line, so rdata is all ones or all zeros. rdata changes one clock edge after the read cycle and holds between reads.
- R8: rdata captures the state as it stood before any write the other port makes in the same cycle.
- R9: If both ports claim the same free semaphore in the same cycle, exactly one side wins: the left side when LEFT_WINS = 1. The loser's claim stays pending.
- R10: After reset every semaphore is free, and both rdata outputs are all ones.
- R11: An access counts only when sem_sel = 1 and mem_en = 0. Any other combination changes neither the semaphore state nor rdata.
- R12: The two ports never both read 0 for the same semaphore.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| l_sem_sel | input | 1 | Left semaphore select |
| l_mem_en | input | 1 | Left memory enable; must be 0 for a semaphore access |
| l_wr | input | 1 | Left write (1) or read (0) |
| l_addr | input | ADDR_W | Left address; only the low bits select the semaphore |
| l_wdata | input | DATA_W | Left write data; only bit 0 is used |
| l_rdata | output | DATA_W | Left registered read value |
| r_sem_sel | input | 1 | Right semaphore select |
| r_mem_en | input | 1 | Right memory enable; must be 0 for a semaphore access |
| r_wr | input | 1 | Right write (1) or read (0) |
| r_addr | input | ADDR_W | Right address |
| r_wdata | input | DATA_W | Right write data |
| r_rdata | output | DATA_W | Right registered read value |

## Verification
A write takes effect at the clock edge that ends its cycle. A read issued in the next cycle captures the new state at its own edge and shows it on rdata. A write is therefore visible two edges after it is driven. Every bench task drives its inputs at the falling edge, waits for the rising edge, and samples rdata 2 ns later. Each check therefore falls exactly one edge after the read that produced it. The same-cycle isolation test depends on this exact edge: the other port's write and the read share one cycle, and the captured value must still show the state from before that edge.

// File: rtl/sem_bank_pkg.sv
package sem_bank_pkg;
   typedef enum logic [1:0] {
      OWN_NONE  = 2'd0,
      OWN_LEFT  = 2'd1,
      OWN_RIGHT = 2'd2
   } own_e;

   localparam int PORT_CNT = 2;
   localparam int PORT_L   = 0;
   localparam int PORT_R   = 1;
endpackage

// File: rtl/sem_port_decode.sv
module sem_port_decode #(
   parameter int NUM_SEM = 8,
   parameter int ADDR_W  = 14,
   parameter int DATA_W  = 16,
   localparam int IDX_W  = $clog2(NUM_SEM)
) (
   input  logic               sem_sel,
   input  logic               mem_en,
   input  logic               wr,
   input  logic [ADDR_W-1:0]  addr,
   input  logic [DATA_W-1:0]  wdata,
   output logic               rd_hit,
   output logic [NUM_SEM-1:0] wr_vec,
   output logic [IDX_W-1:0]   idx,
   output logic               wbit
);
   logic access;

   assign access = sem_sel & ~mem_en;
   assign rd_hit = access & ~wr;
   assign idx    = addr[IDX_W-1:0];
   assign wbit   = wdata[0];

   generate
      for (genvar s = 0; s < NUM_SEM; s++) begin : g_wr
         assign wr_vec[s] = access & wr & (idx == IDX_W'(s));
      end
      if (ADDR_W > IDX_W) begin : g_hi_addr
         logic unused_hi_addr;
         assign unused_hi_addr = ^addr[ADDR_W-1:IDX_W];
      end
      if (DATA_W > 1) begin : g_hi_data
         logic unused_hi_data;
         assign unused_hi_data = ^wdata[DATA_W-1:1];
      end
   endgenerate
endmodule

// File: rtl/sem_cell.sv
module sem_cell
   import sem_bank_pkg::*;
#(
   parameter bit LEFT_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic l_wr_en,
   input  logic l_wbit,
   input  logic r_wr_en,
   input  logic r_wbit,
   output logic view_l,
   output logic view_r
);
   logic req_l, req_r, req_l_nx, req_r_nx;
   own_e owner, owner_nx, tie_owner;

   assign req_l_nx = l_wr_en ? ~l_wbit : req_l;
   assign req_r_nx = r_wr_en ? ~r_wbit : req_r;

   generate
      if (LEFT_WINS) begin : g_tie_left
         assign tie_owner = OWN_LEFT;
      end else begin : g_tie_right
         assign tie_owner = OWN_RIGHT;
      end
   endgenerate

   always_comb begin
      owner_nx = owner;
      unique case (owner)
         OWN_LEFT: begin
            if (!req_l_nx) owner_nx = req_r_nx ? OWN_RIGHT : OWN_NONE;
         end
         OWN_RIGHT: begin
            if (!req_r_nx) owner_nx = req_l_nx ? OWN_LEFT : OWN_NONE;
         end
         default: begin
            if (req_l_nx && req_r_nx) owner_nx = tie_owner;
            else if (req_l_nx)        owner_nx = OWN_LEFT;
            else if (req_r_nx)        owner_nx = OWN_RIGHT;
            else                      owner_nx = OWN_NONE;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_l <= 1'b0;
         req_r <= 1'b0;
         owner <= OWN_NONE;
      end else begin
         req_l <= req_l_nx;
         req_r <= req_r_nx;
         owner <= owner_nx;
      end
   end

   assign view_l = (owner != OWN_LEFT);
   assign view_r = (owner != OWN_RIGHT);
endmodule

// File: rtl/sem_read_port.sv
module sem_read_port #(
   parameter int NUM_SEM = 8,
   parameter int DATA_W  = 16,
   localparam int IDX_W  = $clog2(NUM_SEM)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rd_hit,
   input  logic [IDX_W-1:0]   idx,
   input  logic [NUM_SEM-1:0] views,
   output logic [DATA_W-1:0]  rdata
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rdata <= '1;
      else if (rd_hit) rdata <= {DATA_W{views[idx]}};
   end
endmodule

// File: rtl/sem_token_bank.sv
module sem_token_bank
   import sem_bank_pkg::*;
#(
   parameter int NUM_SEM   = 8,
   parameter int ADDR_W    = 14,
   parameter int DATA_W    = 16,
   parameter bit LEFT_WINS = 1'b1,
   localparam int IDX_W    = $clog2(NUM_SEM)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              l_sem_sel,
   input  logic              l_mem_en,
   input  logic              l_wr,
   input  logic [ADDR_W-1:0] l_addr,
   input  logic [DATA_W-1:0] l_wdata,
   output logic [DATA_W-1:0] l_rdata,
   input  logic              r_sem_sel,
   input  logic              r_mem_en,
   input  logic              r_wr,
   input  logic [ADDR_W-1:0] r_addr,
   input  logic [DATA_W-1:0] r_wdata,
   output logic [DATA_W-1:0] r_rdata
);
   generate
      if (NUM_SEM < 2 || NUM_SEM != (1 << IDX_W)) begin : g_bad_num
         $error("NUM_SEM must be a power of two of at least 2");
      end
      if (ADDR_W < IDX_W) begin : g_bad_addr
         $error("ADDR_W too narrow for NUM_SEM");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("DATA_W must be at least 1");
      end
   endgenerate

   logic              p_sel   [PORT_CNT];
   logic              p_men   [PORT_CNT];
   logic              p_wr    [PORT_CNT];
   logic [ADDR_W-1:0] p_addr  [PORT_CNT];
   logic [DATA_W-1:0] p_wdata [PORT_CNT];
   logic [DATA_W-1:0] p_rdata [PORT_CNT];
   logic              p_rd    [PORT_CNT];
   logic [NUM_SEM-1:0] p_wvec [PORT_CNT];
   logic [IDX_W-1:0]  p_idx   [PORT_CNT];
   logic              p_wbit  [PORT_CNT];
   logic [NUM_SEM-1:0] p_view [PORT_CNT];

   assign p_sel[PORT_L]   = l_sem_sel;
   assign p_men[PORT_L]   = l_mem_en;
   assign p_wr[PORT_L]    = l_wr;
   assign p_addr[PORT_L]  = l_addr;
   assign p_wdata[PORT_L] = l_wdata;
   assign p_sel[PORT_R]   = r_sem_sel;
   assign p_men[PORT_R]   = r_mem_en;
   assign p_wr[PORT_R]    = r_wr;
   assign p_addr[PORT_R]  = r_addr;
   assign p_wdata[PORT_R] = r_wdata;
   assign l_rdata = p_rdata[PORT_L];
   assign r_rdata = p_rdata[PORT_R];

   generate
      for (genvar p = 0; p < PORT_CNT; p++) begin : g_port
         sem_port_decode #(
            .NUM_SEM(NUM_SEM), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
         ) u_dec (
            .sem_sel(p_sel[p]), .mem_en(p_men[p]), .wr(p_wr[p]),
            .addr(p_addr[p]), .wdata(p_wdata[p]),
            .rd_hit(p_rd[p]), .wr_vec(p_wvec[p]),
            .idx(p_idx[p]), .wbit(p_wbit[p])
         );
         sem_read_port #(
            .NUM_SEM(NUM_SEM), .DATA_W(DATA_W)
         ) u_rd (
            .clk(clk), .rst_n(rst_n), .rd_hit(p_rd[p]),
            .idx(p_idx[p]), .views(p_view[p]), .rdata(p_rdata[p])
         );
      end

      for (genvar s = 0; s < NUM_SEM; s++) begin : g_sem
         sem_cell #(.LEFT_WINS(LEFT_WINS)) u_cell (
            .clk(clk), .rst_n(rst_n),
            .l_wr_en(p_wvec[PORT_L][s]), .l_wbit(p_wbit[PORT_L]),
            .r_wr_en(p_wvec[PORT_R][s]), .r_wbit(p_wbit[PORT_R]),
            .view_l(p_view[PORT_L][s]), .view_r(p_view[PORT_R][s])
         );
      end
   endgenerate
endmodule

// File: rtl/sem_bank_checker.sv
module sem_bank_checker #(
   parameter int NUM_SEM = 8,
   parameter int ADDR_W  = 14,
   parameter int DATA_W  = 16,
   localparam int IDX_W  = $clog2(NUM_SEM)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              l_sem_sel,
   input logic              l_mem_en,
   input logic              l_wr,
   input logic [ADDR_W-1:0] l_addr,
   input logic [DATA_W-1:0] l_rdata,
   input logic              r_sem_sel,
   input logic              r_mem_en,
   input logic              r_wr,
   input logic [ADDR_W-1:0] r_addr,
   input logic [DATA_W-1:0] r_rdata
);
   logic l_rd, r_rd, same_idx;
   assign l_rd     = l_sem_sel && !l_mem_en && !l_wr;
   assign r_rd     = r_sem_sel && !r_mem_en && !r_wr;
   assign same_idx = (l_addr[IDX_W-1:0] == r_addr[IDX_W-1:0]);

   assert_reset_free_R10: assert property (@(posedge clk)
      $rose(rst_n) |-> (l_rdata == '1 && r_rdata == '1));

   assert_replicated_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (l_rdata == '0 || l_rdata == '1) && (r_rdata == '0 || r_rdata == '1));

   assert_left_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !l_rd |=> $stable(l_rdata));

   assert_right_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !r_rd |=> $stable(r_rdata));

   assert_exclusive_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (l_rd && r_rd && same_idx) |=> !(l_rdata[0] == 1'b0 && r_rdata[0] == 1'b0));
endmodule

bind sem_token_bank sem_bank_checker #(
   .NUM_SEM(NUM_SEM), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_sem_chk (
   .clk(clk), .rst_n(rst_n),
   .l_sem_sel(l_sem_sel), .l_mem_en(l_mem_en), .l_wr(l_wr),
   .l_addr(l_addr), .l_rdata(l_rdata),
   .r_sem_sel(r_sem_sel), .r_mem_en(r_mem_en), .r_wr(r_wr),
   .r_addr(r_addr), .r_rdata(r_rdata)
);

// File: tb/sem_token_bank_test.sv
`timescale 1ns/1ps
module sem_token_bank_test;
   localparam int AW = 14;
   localparam int DW = 16;
   localparam logic [DW-1:0] ONES  = '1;
   localparam logic [DW-1:0] ZEROS = '0;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic l_sel = 0, l_men = 0, l_wr = 0;
   logic r_sel = 0, r_men = 0, r_wr = 0;
   logic [AW-1:0] l_addr = '0, r_addr = '0;
   logic [DW-1:0] l_wd = '0, r_wd = '0;
   logic [DW-1:0] l_rd, r_rd;
   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #5 clk = ~clk;

   sem_token_bank uut (
      .clk(clk), .rst_n(rst_n),
      .l_sem_sel(l_sel), .l_mem_en(l_men), .l_wr(l_wr),
      .l_addr(l_addr), .l_wdata(l_wd), .l_rdata(l_rd),
      .r_sem_sel(r_sel), .r_mem_en(r_men), .r_wr(r_wr),
      .r_addr(r_addr), .r_wdata(r_wd), .r_rdata(r_rd)
   );

   task automatic check(input string tag, input logic [DW-1:0] act,
                        input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic idle();
      l_sel = 0; l_men = 0; l_wr = 0; l_addr = '0; l_wd = '0;
      r_sel = 0; r_men = 0; r_wr = 0; r_addr = '0; r_wd = '0;
   endtask

   // inputs are set at the falling edge; results sampled 2 ns after the rising edge
   task automatic tick();
      @(posedge clk); #2;
      idle();
      @(negedge clk);
   endtask

   task automatic lwrite(input logic [AW-1:0] a, input logic [DW-1:0] d);
      l_sel = 1; l_wr = 1; l_addr = a; l_wd = d; tick();
   endtask
   task automatic rwrite(input logic [AW-1:0] a, input logic [DW-1:0] d);
      r_sel = 1; r_wr = 1; r_addr = a; r_wd = d; tick();
   endtask
   task automatic lread(input logic [AW-1:0] a, output logic [DW-1:0] v);
      l_sel = 1; l_wr = 0; l_addr = a;
      @(posedge clk); #2; v = l_rd; idle(); @(negedge clk);
   endtask
   task automatic rread(input logic [AW-1:0] a, output logic [DW-1:0] v);
      r_sel = 1; r_wr = 0; r_addr = a;
      @(posedge clk); #2; v = r_rd; idle(); @(negedge clk);
   endtask

   task automatic test_reset();
      logic [DW-1:0] v;
      check("R10 left rdata after reset", l_rd, ONES);
      check("R10 right rdata after reset", r_rd, ONES);
      for (int s = 0; s < 8; s++) begin
         lread(AW'(s), v); check("R10 left view free", v, ONES);
         rread(AW'(s), v); check("R10 right view free", v, ONES);
      end
   endtask

   task automatic test_claim_pass();
      logic [DW-1:0] v;
      lwrite(14'd2, 16'h0000);
      lread(14'd2, v); check("R3 claimer reads 0", v, ZEROS);
      rread(14'd2, v); check("R3 other reads 1 on all lines R7", v, ONES);
      rwrite(14'd2, 16'h0000);
      lread(14'd2, v); check("R4 owner unchanged by other claim", v, ZEROS);
      rread(14'd2, v); check("R4 non-owner still reads 1", v, ONES);
      lwrite(14'd2, 16'h0001);
      rread(14'd2, v); check("R5 pending side now owns", v, ZEROS);
      lread(14'd2, v); check("R5 old owner reads 1", v, ONES);
      rwrite(14'd2, 16'h0001);
      lread(14'd2, v); check("R6 free left", v, ONES);
      rread(14'd2, v); check("R6 free right", v, ONES);
   endtask

   task automatic test_cancel();
      logic [DW-1:0] v;
      lwrite(14'd3, 16'h0000);
      rwrite(14'd3, 16'h0000);
      rwrite(14'd3, 16'h0001);
      lwrite(14'd3, 16'h0001);
      rread(14'd3, v); check("R4 cancelled claim not granted", v, ONES);
      lread(14'd3, v); check("R6 free after release", v, ONES);
   endtask

   task automatic test_data_bit();
      logic [DW-1:0] v;
      lwrite(14'd5, 16'hFFFE);
      lread(14'd5, v); check("R2 bit0=0 claims", v, ZEROS);
      lwrite(14'd5, 16'h5555);
      lread(14'd5, v); check("R2 bit0=1 releases", v, ONES);
      rwrite(14'd5, 16'hAAAA);
      rread(14'd5, v); check("R2 right bit0=0 claims", v, ZEROS);
      rwrite(14'd5, 16'h0001);
   endtask

   task automatic test_addr();
      logic [DW-1:0] v;
      lwrite(14'h3FF9, 16'h0000);
      lread(14'h0009, v); check("R1 high bits ignored left", v, ZEROS);
      rread(14'h2001, v); check("R1 high bits ignored right", v, ONES);
      lread(14'd0, v); check("R1 neighbour untouched", v, ONES);
      lwrite(14'h1001, 16'h0001);
      rread(14'd1, v); check("R1 release via alias", v, ONES);
   endtask

   task automatic test_gate();
      logic [DW-1:0] v;
      l_sel = 1; l_men = 1; l_wr = 1; l_addr = 14'd4; l_wd = 16'h0000; tick();
      l_sel = 0; l_men = 0; l_wr = 1; l_addr = 14'd4; l_wd = 16'h0000; tick();
      rwrite(14'd4, 16'h0000);
      rread(14'd4, v); check("R11 gated claims ignored", v, ZEROS);
      l_sel = 1; l_men = 1; l_wr = 0; l_addr = 14'd0;
      @(posedge clk); #2; v = l_rd; idle(); @(negedge clk);
      check("R11 gated read keeps rdata", v, ONES);
      lread(14'd4, v); check("R11 real read sees right owner", v, ONES);
      r_sel = 1; r_men = 1; r_wr = 0; r_addr = 14'd0;
      @(posedge clk); #2; v = r_rd; idle(); @(negedge clk);
      check("R11 gated right read keeps rdata", v, ZEROS);
      rwrite(14'd4, 16'h0001);
   endtask

   task automatic test_tie();
      logic [DW-1:0] v;
      l_sel = 1; l_wr = 1; l_addr = 14'd6; l_wd = 16'h0000;
      r_sel = 1; r_wr = 1; r_addr = 14'd6; r_wd = 16'h0000;
      tick();
      l_sel = 1; l_addr = 14'd6; r_sel = 1; r_addr = 14'd6;
      @(posedge clk); #2;
      check("R9 left wins tie", l_rd, ZEROS);
      check("R9 right loses tie", r_rd, ONES);
      idle(); @(negedge clk);
      lwrite(14'd6, 16'h0001);
      rread(14'd6, v); check("R9 loser claim kept pending", v, ZEROS);
      rwrite(14'd6, 16'h0001);
   endtask

   task automatic test_isolation();
      logic [DW-1:0] v;
      lwrite(14'd7, 16'h0000);
      rwrite(14'd7, 16'h0000);
      l_sel = 1; l_wr = 1; l_addr = 14'd7; l_wd = 16'h0001;
      r_sel = 1; r_wr = 0; r_addr = 14'd7;
      @(posedge clk); #2; v = r_rd; idle(); @(negedge clk);
      check("R8 read captures pre-write state", v, ONES);
      repeat (3) @(negedge clk);
      check("R7 rdata holds between reads", r_rd, ONES);
      rread(14'd7, v); check("R8 next read shows handover", v, ZEROS);
      rwrite(14'd7, 16'h0001);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      test_reset();
      test_claim_pass();
      test_cancel();
      test_data_bit();
      test_addr();
      test_gate();
      test_tie();
      test_isolation();
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=running expected=done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule